// File: doc/BRIEF.md
# Operand Address Resolver

This unit sits between instruction fetch and execute in a small 24-bit accumulator processor with a 1024-word memory. It receives a fetched instruction word and the current index register. From the mode flags in the word it produces either a literal operand or a resolved memory address. Opcode handling belongs to the next stage.

Bit numbering counts from the most significant end: doc bit k is `instr[23-k]`. The three mode flags are `instr[15]` (literal), `instr[14]` (add index) and `instr[13]` (go through a pointer word). When the literal flag is set, the other two flags are ignored. For every other mode the low 13 bits `instr[12:0]` form the address field. Pointer modes issue one extra memory read and hold a request/valid handshake until the word returns.

Every address the unit would use is compared with the memory size. A failure ends the operation at once with an error flag, and no read is issued for an out-of-range pointer location.

Top module: `ea_unit`

## Requirements
- R1: When `instr[15]`=1 the result is a literal, whatever `instr[14]` and `instr[13]` hold.
- R2: A literal result is `instr[14:0]` zero-extended to 24 bits. It comes with `is_imm`=1 and `addr_err`=0, and `done` pulses in the cycle after the `start` edge.
- R3: With `instr[15:13]`=000 (direct), `value` is `instr[12:0]` zero-extended and `is_imm`=0. `done` pulses in the cycle after `start`, and no read is requested.
- R4: With `instr[15:13]`=010 (indexed), the address is (`instr[12:0]` + `x_reg[12:0]`) modulo 8192. It completes in the cycle after `start`. Bits of `x_reg` above bit 12 have no effect.
- R5: With `instr[15:13]`=001 (pointer), `mem_rd_req` rises in the cycle after `start`, with `mem_rd_addr` = `instr[9:0]`. Both hold, and `done` stays low, until `mem_rd_valid` is sampled high. `done` then pulses on the next cycle, with `value` = `mem_rd_data[12:0]` zero-extended.
- R6: With `instr[15:13]`=011 (indexed pointer), the index is added first, modulo 8192. The pointer word is then read at that sum, and the result is taken as in R5.
- R7: An address of 1024 or more raises `addr_err`, which pulses only together with `done`. This covers a direct or indexed address and a pointer word's low 13 bits. `value` then carries the offending 13-bit address.
- R8: In the pointer modes, an out-of-range pointer location completes with `done` and `addr_err` in the cycle after `start`, and `mem_rd_req` never rises.
- R9: A `start` pulse while a read is outstanding is ignored, and the result belongs to the first instruction.
- R10: During and right after reset, `done`, `addr_err` and `mem_rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin resolving `instr` (sampled when idle) |
| instr | input | 24 | Fetched instruction word |
| x_reg | input | 24 | Current index register |
| mem_rd_req | output | 1 | Pointer-word read request, held until valid |
| mem_rd_addr | output | 10 | Pointer-word location |
| mem_rd_valid | input | 1 | Read data present this cycle |
| mem_rd_data | input | 24 | Pointer word |
| done | output | 1 | One-cycle result strobe |
| is_imm | output | 1 | Result is a literal operand |
| value | output | 24 | Literal operand or resolved address |
| addr_err | output | 1 | Address out of range, valid with `done` |

## Verification
A wrongly decoded mode is visible in the cycle after `start`. It shows up as a literal where an address was due, or a read request where none was due. A stuck wait state shows up as a `done` that never arrives, or as a second read request. A wrong sum or a lost bound check shows as a bad `value` or `addr_err` on the first `done` strobe. Response latency is varied from zero to several cycles, and a stray `start` is injected mid-wait, so that handshake faults reach the ports within a few cycles.

// File: rtl/ea_pkg.sv
// Shared types and flag positions for the operand address resolver.
// Positions are counted from the most significant bit of the word.
package ea_pkg;
    typedef enum logic [2:0] {
        MODE_DIRECT,
        MODE_INDEXED,
        MODE_INDIRECT,
        MODE_IDX_IND,
        MODE_IMM
    } ea_mode_e;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } ea_state_e;

    localparam int LIT_FLAG_POS   = 8;
    localparam int IDX_FLAG_POS   = 9;
    localparam int PTR_FLAG_POS   = 10;
    localparam int LIT_START_POS  = 9;
    localparam int FIELD_START_POS = 11;
    localparam int OPCODE_W       = 8;
endpackage

// File: rtl/ea_mode_decode.sv
// Mode decoder: splits an instruction word into the addressing mode,
// the address field and the zero-extended literal.
// Assumes: flag positions from ea_pkg, counted from the MSB; the literal
// flag overrides the other two.
module ea_mode_decode
    import ea_pkg::*;
#(
    parameter int WORD_W = 24,
    localparam int FIELD_W = WORD_W - FIELD_START_POS,
    localparam int LIT_W   = WORD_W - LIT_START_POS
) (
    input  logic [WORD_W-1:0]  instr,
    output ea_mode_e           mode,
    output logic [FIELD_W-1:0] field,
    output logic [WORD_W-1:0]  literal,
    output logic               needs_read,
    output logic               uses_index
);
    localparam int BIT_LIT = WORD_W - 1 - LIT_FLAG_POS;
    localparam int BIT_IDX = WORD_W - 1 - IDX_FLAG_POS;
    localparam int BIT_PTR = WORD_W - 1 - PTR_FLAG_POS;

    logic unused_opcode;
    assign unused_opcode = ^instr[WORD_W-1 -: OPCODE_W];

    // Pick the mode; literal flag takes priority over index and pointer.
    always_comb begin
        if (instr[BIT_LIT]) begin
            mode = MODE_IMM;
        end else begin
            unique case ({instr[BIT_IDX], instr[BIT_PTR]})
                2'b00:   mode = MODE_DIRECT;
                2'b10:   mode = MODE_INDEXED;
                2'b01:   mode = MODE_INDIRECT;
                default: mode = MODE_IDX_IND;
            endcase
        end
    end

    // Derive the per-mode control flags.
    always_comb begin
        needs_read = (mode == MODE_INDIRECT) || (mode == MODE_IDX_IND);
        uses_index = (mode == MODE_INDEXED)  || (mode == MODE_IDX_IND);
    end

    // Extract the address field and zero-fill the literal.
    always_comb begin
        field   = instr[FIELD_W-1:0];
        literal = {{(WORD_W-LIT_W){1'b0}}, instr[LIT_W-1:0]};
    end

    always_comb begin
        if (instr[BIT_LIT]) begin
            a_lit_override_r1: assert (mode == MODE_IMM && !needs_read);
        end
    end
endmodule

// File: rtl/ea_index_add.sv
// Index adder: optionally adds the low bits of the index register to the
// address field, wrapping at the field width.
// Assumes: index bits above the field width are irrelevant.
module ea_index_add #(
    parameter int WORD_W  = 24,
    parameter int FIELD_W = 13
) (
    input  logic [FIELD_W-1:0] field,
    input  logic [WORD_W-1:0]  x_val,
    input  logic               use_index,
    output logic [FIELD_W-1:0] addr
);
    logic unused_x_hi;
    assign unused_x_hi = ^x_val[WORD_W-1:FIELD_W];

    // Form the wrapped sum, or pass the field through.
    always_comb begin
        if (use_index) begin
            addr = field + x_val[FIELD_W-1:0];
        end else begin
            addr = field;
        end
    end
endmodule

// File: rtl/ea_bound_check.sv
// Bound checker: flags whether an address falls inside the memory.
// Assumes: MEM_DEPTH does not exceed 2**FIELD_W.
module ea_bound_check #(
    parameter int FIELD_W   = 13,
    parameter int MEM_DEPTH = 1024
) (
    input  logic [FIELD_W-1:0] addr,
    output logic               in_range
);
    localparam logic [FIELD_W:0] LIMIT = (FIELD_W+1)'(MEM_DEPTH);

    // Compare against the memory size with one spare bit of headroom.
    always_comb begin
        in_range = ({1'b0, addr} < LIMIT);
    end
endmodule

// File: rtl/ea_unit.sv
// Operand address resolver, top level.
// Resolves a literal or an effective address from an instruction word.
// Pointer modes run a request/valid read for the pointer word.
// Assumes: the read port keeps mem_rd_data valid in the cycle mem_rd_valid
// is high; start is only honoured while idle.
module ea_unit
    import ea_pkg::*;
#(
    parameter int WORD_W    = 24,
    parameter int MEM_DEPTH = 1024,
    localparam int ADDR_W   = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] x_reg,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              done,
    output logic              is_imm,
    output logic [WORD_W-1:0] value,
    output logic              addr_err
);
    localparam int FIELD_W = WORD_W - FIELD_START_POS;

    ea_mode_e           dec_mode;
    logic [FIELD_W-1:0] dec_field;
    logic [WORD_W-1:0]  dec_lit;
    logic               dec_needs_read;
    logic               dec_uses_index;
    logic [FIELD_W-1:0] ea;
    logic               ea_ok;
    logic [FIELD_W-1:0] fin;
    logic               fin_ok;

    ea_state_e          state_q;
    logic               req_q;
    logic [ADDR_W-1:0]  addr_q;
    logic               done_q;
    logic               err_q;
    logic               imm_q;
    logic [WORD_W-1:0]  value_q;

    logic unused_rd_hi;
    assign unused_rd_hi = ^mem_rd_data[WORD_W-1:FIELD_W];

    ea_mode_decode #(.WORD_W(WORD_W)) u_dec (
        .instr      (instr),
        .mode       (dec_mode),
        .field      (dec_field),
        .literal    (dec_lit),
        .needs_read (dec_needs_read),
        .uses_index (dec_uses_index)
    );

    ea_index_add #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_add (
        .field     (dec_field),
        .x_val     (x_reg),
        .use_index (dec_uses_index),
        .addr      (ea)
    );

    ea_bound_check #(.FIELD_W(FIELD_W), .MEM_DEPTH(MEM_DEPTH)) u_chk_ea (
        .addr     (ea),
        .in_range (ea_ok)
    );

    // The pointer word's low bits form the final address.
    always_comb begin
        fin = mem_rd_data[FIELD_W-1:0];
    end

    ea_bound_check #(.FIELD_W(FIELD_W), .MEM_DEPTH(MEM_DEPTH)) u_chk_fin (
        .addr     (fin),
        .in_range (fin_ok)
    );

    // Sequencer: launch on start, wait for the pointer word, strobe done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            req_q   <= 1'b0;
            addr_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            imm_q   <= 1'b0;
            value_q <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (dec_mode == MODE_IMM) begin
                            done_q  <= 1'b1;
                            imm_q   <= 1'b1;
                            value_q <= dec_lit;
                        end else if (dec_needs_read && ea_ok) begin
                            state_q <= ST_WAIT;
                            req_q   <= 1'b1;
                            addr_q  <= ea[ADDR_W-1:0];
                        end else begin
                            done_q  <= 1'b1;
                            imm_q   <= 1'b0;
                            err_q   <= !ea_ok;
                            value_q <= {{(WORD_W-FIELD_W){1'b0}}, ea};
                        end
                    end
                end
                default: begin
                    if (mem_rd_valid) begin
                        state_q <= ST_IDLE;
                        req_q   <= 1'b0;
                        done_q  <= 1'b1;
                        imm_q   <= 1'b0;
                        err_q   <= !fin_ok;
                        value_q <= {{(WORD_W-FIELD_W){1'b0}}, fin};
                    end
                end
            endcase
        end
    end

    // Drive the ports from the registered state.
    always_comb begin
        mem_rd_req  = req_q;
        mem_rd_addr = addr_q;
        done        = done_q;
        addr_err    = err_q;
        is_imm      = imm_q;
        value       = value_q;
    end

    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> !done && !addr_err && !mem_rd_req);

    p_fast_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && !dec_needs_read) |=> done && !mem_rd_req);

    p_lit_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && is_imm) |-> !addr_err);

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> mem_rd_req && $stable(mem_rd_addr) && !done);

    p_done_after_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_valid) |=> done && !mem_rd_req && !is_imm);

    p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> done);

    p_no_oob_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && dec_needs_read && !ea_ok)
        |=> done && addr_err && !mem_rd_req);

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid && start) |=> $stable(mem_rd_addr));
endmodule

// File: tb/sim_ea_unit.sv
`timescale 1ns/1ps
module sim_ea_unit;
    localparam int WORD_W = 24;
    localparam int DEPTH  = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [WORD_W-1:0] instr = '0;
    logic [WORD_W-1:0] x_reg = '0;
    logic              mem_rd_req;
    logic [9:0]        mem_rd_addr;
    logic              mem_rd_valid = 1'b0;
    logic [WORD_W-1:0] mem_rd_data = '0;
    logic              done;
    logic              is_imm;
    logic [WORD_W-1:0] value;
    logic              addr_err;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ea_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .x_reg(x_reg),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .done(done), .is_imm(is_imm), .value(value), .addr_err(addr_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] mem_word(input logic [9:0] a);
        logic [12:0] lo;
        lo = (a[1:0] == 2'b00) ? 13'(a * 13 + 5) : {3'b000, 10'(a * 37 + 11)};
        return {11'(a * 7 + 3), lo};
    endfunction

    function automatic logic [WORD_W-1:0] mk(input logic [7:0] op, input bit lit,
                                             input bit idx, input bit ptr,
                                             input logic [14:0] low);
        if (lit) return {op, 1'b1, low};
        return {op, 1'b0, idx, ptr, low[12:0]};
    endfunction

    // Pointer location (or direct/indexed address) as 13 bits.
    function automatic logic [12:0] exp_ea(input logic [WORD_W-1:0] w, input logic [WORD_W-1:0] xv);
        return w[14] ? 13'(w[12:0] + xv[12:0]) : w[12:0];
    endfunction

    // One full transaction with checks; lat = response delay in cycles.
    task automatic run(input logic [WORD_W-1:0] w, input logic [WORD_W-1:0] xv,
                       input int lat, input bit poke_busy, input string tag);
        logic [12:0] ea;
        logic [9:0]  ra;
        logic [WORD_W-1:0] rd;
        logic [12:0] fin;
        @(negedge clk);
        start = 1'b1; instr = w; x_reg = xv;
        @(negedge clk);
        start = 1'b0; instr = $urandom; x_reg = $urandom;
        ea = exp_ea(w, xv);
        if (w[15]) begin
            check(done === 1'b1 && is_imm === 1'b1 && addr_err === 1'b0 && mem_rd_req === 1'b0,
                  {tag, " R1 R2 literal flags"}, {done, is_imm, addr_err, mem_rd_req}, 4'b1100);
            check(value === {9'd0, w[14:0]}, {tag, " R2 literal value"}, value, {9'd0, w[14:0]});
        end else if (!w[13] || ea >= 13'(DEPTH)) begin
            check(done === 1'b1 && is_imm === 1'b0 && mem_rd_req === 1'b0,
                  {tag, " R3 R4 R8 done next cycle, no read"}, {done, is_imm, mem_rd_req}, 3'b100);
            check(addr_err === (ea >= 13'(DEPTH)), {tag, " R7 R8 range flag"}, addr_err, ea >= 13'(DEPTH));
            check(value === {11'd0, ea}, {tag, " R3 R4 address"}, value, {11'd0, ea});
        end else begin
            ra = ea[9:0];
            check(done === 1'b0 && mem_rd_req === 1'b1 && mem_rd_addr === ra,
                  {tag, " R5 R6 read request"}, {done, mem_rd_req, 2'b00, mem_rd_addr}, {2'b01, 2'b00, ra});
            for (int i = 0; i < lat; i++) begin
                if (poke_busy && i == 0) begin
                    start = 1'b1; instr = mk(8'h3C, 1'b1, 1'b0, 1'b0, 15'h1234);
                end
                @(negedge clk);
                start = 1'b0;
                check(done === 1'b0 && mem_rd_req === 1'b1 && mem_rd_addr === ra,
                      {tag, " R5 R9 hold while waiting"}, {done, mem_rd_req, 2'b00, mem_rd_addr}, {2'b01, 2'b00, ra});
            end
            rd = mem_word(ra);
            mem_rd_valid = 1'b1; mem_rd_data = rd;
            @(negedge clk);
            mem_rd_valid = 1'b0; mem_rd_data = $urandom;
            fin = rd[12:0];
            check(done === 1'b1 && mem_rd_req === 1'b0 && is_imm === 1'b0,
                  {tag, " R5 done after valid"}, {done, mem_rd_req, is_imm}, 3'b100);
            check(addr_err === (fin >= 13'(DEPTH)), {tag, " R7 final range"}, addr_err, fin >= 13'(DEPTH));
            check(value === {11'd0, fin}, {tag, " R5 R6 final address"}, value, {11'd0, fin});
        end
        @(negedge clk);
        check(done === 1'b0, {tag, " R9 single strobe"}, done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        check(done === 1'b0 && addr_err === 1'b0 && mem_rd_req === 1'b0,
              "R10 reset state", {done, addr_err, mem_rd_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done === 1'b0 && mem_rd_req === 1'b0, "R10 after reset", {done, mem_rd_req}, 0);

        // Directed corners.
        run({8'h50, 1'b1, 2'b11, 13'h0ABC}, 24'h0, 0, 0, "R1 flags 9/10 set under literal");
        run(mk(8'h00, 1, 0, 0, 15'h7FFF), 24'h5, 0, 0, "R2 max literal");
        run(mk(8'h00, 0, 0, 0, 15'd0), 24'h0, 0, 0, "R3 direct 0");
        run(mk(8'h0C, 0, 0, 0, 15'd1023), 24'h0, 0, 0, "R3 direct top");
        run(mk(8'h0C, 0, 0, 0, 15'd1024), 24'h0, 0, 0, "R7 direct 1024");
        run(mk(8'h0C, 0, 0, 0, 15'd8191), 24'h0, 0, 0, "R7 direct max");
        run(mk(8'h40, 0, 1, 0, 15'd8190), 24'd3, 0, 0, "R4 indexed wrap");
        run(mk(8'h40, 0, 1, 0, 15'd10), 24'hFFE005, 0, 0, "R4 index high bits ignored");
        run(mk(8'h40, 0, 1, 0, 15'd1000), 24'd24, 0, 0, "R7 indexed lands 1024");
        run(mk(8'h3C, 0, 0, 1, 15'd0), 24'h0, 0, 0, "R5 pointer zero latency");
        run(mk(8'h3C, 0, 0, 1, 15'd7), 24'h0, 3, 0, "R5 pointer slow");
        run(mk(8'h3C, 0, 0, 1, 15'd100), 24'h0, 1, 0, "R7 pointer final oob");
        run(mk(8'h48, 0, 0, 1, 15'd2000), 24'h0, 0, 0, "R8 pointer location oob");
        run(mk(8'h48, 0, 1, 1, 15'd1020), 24'd10, 0, 0, "R8 indexed pointer oob");
        run(mk(8'h48, 0, 1, 1, 15'd8000), 24'd300, 2, 0, "R6 indexed pointer wrap");
        run(mk(8'h28, 0, 0, 1, 15'd9), 24'h0, 2, 1, "R9 start while busy");

        // Constrained random.
        for (int n = 0; n < 400; n++) begin
            logic [14:0] low;
            logic [WORD_W-1:0] xv;
            low = ($urandom % 4 == 0) ? 15'($urandom) : 15'($urandom % 1024);
            xv  = ($urandom % 3 == 0) ? WORD_W'($urandom) : WORD_W'($urandom % 64);
            run(mk(8'($urandom), ($urandom % 5) == 0, 1'($urandom), 1'($urandom), low),
                xv, $urandom % 4, ($urandom % 8) == 0, "random");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule